// File: doc/BRIEF.md
# Selectable-Rate System Clock Controller with Single-Step

This block produces the clock enable for a slow hobby processor from a fast reference clock. In automatic mode it divides the reference down to one of two preset rates, which default to 2 Hz and 10 Hz. A rate-select input chooses between them. In step mode it issues exactly one enable pulse for each press of a step button. The processor's flops then advance only on cycles where the enable is high.

The step and reset buttons are raw, bouncing contacts. Each one goes through a two-flop synchronizer and then a stability filter before it is used. The rate and mode switches are synchronized only. A debounced reset button, or the block's own asynchronous reset, drives a system reset that is released synchronously. The processor can drive an active-low halt input that freezes all clocking. Whenever clocking stops (halt, reset or step mode), the divider restarts. A rate change also restarts it. As a result, the first automatic pulse afterwards always comes a full period later.

Top module: `sysclk_ctrl`

## Requirements
- R1: While `arst_n` is low, `sys_rst_o` is 1 and `sys_clk_en_o` is 0. After `arst_n` rises, `sys_rst_o` stays 1 through the first rising clock edge and falls at the second.
- R2: In automatic mode (`auto_mode_i`=1) with `rate_fast_i`=0, pulses repeat every REF_HZ/SLOW_HZ reference cycles.
- R3: In automatic mode with `rate_fast_i`=1, pulses repeat every REF_HZ/FAST_HZ reference cycles.
- R4: A change of `rate_fast_i` restarts the divider. The interval that spans the change therefore equals the time from the last pulse to the restart plus one full new period, and is never cut short.
- R5: In step mode (`auto_mode_i`=0), each accepted press of `step_btn_i` (rising edge of the filtered level) gives exactly one pulse, and no automatic pulses occur.
- R6: A button level is accepted only after the synchronized input has differed from the accepted level for DEBOUNCE_CYCLES consecutive cycles. A shorter glitch on either button causes no pulse and no reset.
- R7: While `halt_n_i` is 0, no pulse is produced in either mode. A step press made while halted is lost. After release, automatic pulses resume at the selected period.
- R8: A held press of `reset_btn_i` drives `sys_rst_o` to 1 and suppresses all pulses. `sys_rst_o` returns to 0 a few cycles after the filtered release.
- R9: Every pulse on `sys_clk_en_o` lasts exactly one reference cycle, and no pulse occurs while `sys_rst_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| rate_fast_i | input | 1 | Rate select: 0 = slow preset, 1 = fast preset |
| auto_mode_i | input | 1 | 1 = automatic clocking, 0 = manual step |
| step_btn_i | input | 1 | Raw step button, 1 = pressed |
| reset_btn_i | input | 1 | Raw reset button, 1 = pressed |
| halt_n_i | input | 1 | Active-low halt from the processor, synchronous to `clk_ref` |
| sys_clk_en_o | output | 1 | One-cycle system clock enable pulse |
| sys_rst_o | output | 1 | Synchronized system reset, active high |

## Verification
The assertions assume that `halt_n_i` is already synchronous to `clk_ref`. They also assume that both division terms are at least two, so that back-to-back pulses cannot be legal. The bench therefore drives every input, including the bouncing button patterns, one time unit after a falling edge. It also uses a small reference frequency whose terms are 100 and 20 cycles. The bounce bursts it applies are one or two cycles long and stay below the four-cycle filter window. The real presses are held for many times that window.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef enum logic {
    CLK_MODE_STEP = 1'b0,
    CLK_MODE_AUTO = 1'b1
  } clk_mode_e;

  // Reference cycles per output period for a requested rate.
  function automatic int unsigned div_term(input int unsigned ref_hz,
                                           input int unsigned out_hz);
    return ref_hz / out_hz;
  endfunction

endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

endmodule

// File: rtl/sysclk_debounce.sv
module sysclk_debounce #(
  parameter int unsigned STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic raw_i,
  output logic level_o
);

  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);

  logic          sync_lvl;
  logic          db_q, db_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differ;

  sysclk_sync #(.W(1)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d_i    (raw_i),
    .q_o    (sync_lvl)
  );

  always_comb begin
    differ = sync_lvl ^ db_q;
    db_d   = db_q;
    cnt_d  = '0;
    if (differ) begin
      if (cnt_q == CW'(STABLE_CYCLES - 1)) begin
        db_d = sync_lvl;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      db_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      db_q  <= db_d;
      cnt_q <= cnt_d;
    end
  end

  assign level_o = db_q;

  // R6: an accepted change always takes the level the synchronizer showed
  assert_db_takes_sync_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (db_q != $past(db_q)) |-> (db_q == $past(sync_lvl)));

  // R6: a change is accepted only after the filter window has been filled
  assert_db_window_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (db_q != $past(db_q)) |-> ($past(cnt_q) == CW'(STABLE_CYCLES - 1)));

endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider #(
  parameter int unsigned SLOW_TERM = 100,
  parameter int unsigned FAST_TERM = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);

  localparam int unsigned MAX_TERM = (SLOW_TERM > FAST_TERM) ? SLOW_TERM : FAST_TERM;
  localparam int unsigned CW       = $clog2(MAX_TERM + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_val;
  logic          fast_q;
  logic          restart;

  always_comb begin
    last_val = fast_i ? CW'(FAST_TERM - 1) : CW'(SLOW_TERM - 1);
    restart  = !run_i || (fast_i != fast_q);
    if (restart || (cnt_q == last_val)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    tick_o = !restart && (cnt_q == last_val);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fast_q <= fast_i;
    end
  end

  // R2: the counter never leaves the longest period
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q < CW'(MAX_TERM));

  // R4: a rate change is followed by a counter restart
  assert_restart_on_rate_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (fast_i != fast_q) |=> (cnt_q == '0));

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl #(
  parameter int unsigned REF_HZ          = 50_000_000,
  parameter int unsigned SLOW_HZ         = 2,
  parameter int unsigned FAST_HZ         = 10,
  parameter int unsigned DEBOUNCE_CYCLES = 500_000
) (
  input  logic clk_ref,
  input  logic arst_n,
  input  logic rate_fast_i,
  input  logic auto_mode_i,
  input  logic step_btn_i,
  input  logic reset_btn_i,
  input  logic halt_n_i,
  output logic sys_clk_en_o,
  output logic sys_rst_o
);
  import sysclk_pkg::*;

  localparam int unsigned SLOW_TERM = div_term(REF_HZ, SLOW_HZ);
  localparam int unsigned FAST_TERM = div_term(REF_HZ, FAST_HZ);

  logic [1:0] sw_sync;
  clk_mode_e  mode_s;
  logic       fast_s;
  logic       step_lvl, rst_lvl;
  logic       step_prev_q;
  logic       step_rise;
  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       pulse_q, pulse_d;
  logic       run;
  logic       div_tick;

  sysclk_sync #(.W(2)) u_sw_sync (
    .clk    (clk_ref),
    .arst_n (arst_n),
    .d_i    ({auto_mode_i, rate_fast_i}),
    .q_o    (sw_sync)
  );

  assign mode_s = clk_mode_e'(sw_sync[1]);
  assign fast_s = sw_sync[0];

  sysclk_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_step_db (
    .clk     (clk_ref),
    .arst_n  (arst_n),
    .raw_i   (step_btn_i),
    .level_o (step_lvl)
  );

  sysclk_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_rst_db (
    .clk     (clk_ref),
    .arst_n  (arst_n),
    .raw_i   (reset_btn_i),
    .level_o (rst_lvl)
  );

  assign run = (mode_s == CLK_MODE_AUTO) && halt_n_i && !rst_pipe_q[1];

  sysclk_divider #(.SLOW_TERM(SLOW_TERM), .FAST_TERM(FAST_TERM)) u_div (
    .clk    (clk_ref),
    .arst_n (arst_n),
    .run_i  (run),
    .fast_i (fast_s),
    .tick_o (div_tick)
  );

  always_comb begin
    step_rise  = step_lvl && !step_prev_q;
    rst_pipe_d = rst_lvl ? 2'b11 : {rst_pipe_q[0], 1'b0};
    pulse_d    = 1'b0;
    if (!rst_pipe_d[1] && halt_n_i) begin
      if (mode_s == CLK_MODE_AUTO) begin
        pulse_d = div_tick;
      end else begin
        pulse_d = step_rise;
      end
    end
  end

  always_ff @(posedge clk_ref or negedge arst_n) begin
    if (!arst_n) begin
      rst_pipe_q  <= 2'b11;
      step_prev_q <= 1'b0;
      pulse_q     <= 1'b0;
    end else begin
      rst_pipe_q  <= rst_pipe_d;
      step_prev_q <= step_lvl;
      pulse_q     <= pulse_d;
    end
  end

  assign sys_clk_en_o = pulse_q;
  assign sys_rst_o    = rst_pipe_q[1];

  // R9: reset and enable never overlap
  assert_no_pulse_in_reset_R9: assert property (@(posedge clk_ref) disable iff (!arst_n)
    sys_rst_o |-> !sys_clk_en_o);

  // R9: pulses are single-cycle
  assert_single_cycle_R9: assert property (@(posedge clk_ref) disable iff (!arst_n)
    sys_clk_en_o |=> !sys_clk_en_o);

  // R7: an asserted halt blocks the next enable
  assert_halt_blocks_R7: assert property (@(posedge clk_ref) disable iff (!arst_n)
    !halt_n_i |=> !sys_clk_en_o);

  // R8: an accepted reset press holds the system reset
  assert_btn_holds_reset_R8: assert property (@(posedge clk_ref) disable iff (!arst_n)
    rst_lvl |=> sys_rst_o);

endmodule

// File: tb/sysclk_ctrl_bench.sv
module sysclk_ctrl_bench;

  logic clk = 1'b0;
  logic arst_n;
  logic rate_fast, auto_mode, step_btn, reset_btn, halt_n;
  logic sys_clk_en, sys_rst;

  always #4 clk = ~clk;

  sysclk_ctrl #(
    .REF_HZ(200), .SLOW_HZ(2), .FAST_HZ(10), .DEBOUNCE_CYCLES(4)
  ) u_sysclk_ctrl (
    .clk_ref      (clk),
    .arst_n       (arst_n),
    .rate_fast_i  (rate_fast),
    .auto_mode_i  (auto_mode),
    .step_btn_i   (step_btn),
    .reset_btn_i  (reset_btn),
    .halt_n_i     (halt_n),
    .sys_clk_en_o (sys_clk_en),
    .sys_rst_o    (sys_rst)
  );

  int checks = 0;
  int failures = 0;

  // pulse monitor, sampled on falling edges
  int cyc = 0;
  int pulse_cnt, wide_cnt, n_gaps, first_gap, min_gap, max_gap, last_pulse;
  bit have_last = 1'b0;
  bit prev_en = 1'b0;
  bit rst_seen;

  always @(negedge clk) begin
    cyc++;
    if (sys_rst) rst_seen = 1'b1;
    if (sys_clk_en) begin
      if (have_last) begin
        int gap;
        gap = cyc - last_pulse;
        if (n_gaps == 0) first_gap = gap;
        if (gap < min_gap) min_gap = gap;
        if (gap > max_gap) max_gap = gap;
        n_gaps++;
      end
      last_pulse = cyc;
      have_last = 1'b1;
      pulse_cnt++;
      if (prev_en) wide_cnt++;
    end
    prev_en = sys_clk_en;
  end

  task automatic clear_stats(input bit forget_last);
    pulse_cnt = 0; wide_cnt = 0; n_gaps = 0; first_gap = 0;
    min_gap = 1_000_000; max_gap = 0; rst_seen = 1'b0;
    if (forget_last) have_last = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input int hold);
    step_btn = 1; wait_cyc(1); step_btn = 0; wait_cyc(1);
    step_btn = 1; wait_cyc(1); step_btn = 0; wait_cyc(2);
    step_btn = 1; wait_cyc(hold);
    step_btn = 0; wait_cyc(1); step_btn = 1; wait_cyc(1);
    step_btn = 0; wait_cyc(20);
  endtask

  task automatic t_reset();
    arst_n = 0; rate_fast = 0; auto_mode = 1; step_btn = 0; reset_btn = 0; halt_n = 1;
    wait_cyc(3);
    check(sys_rst == 1'b1, "R1 rst during arst", sys_rst, 1);
    check(sys_clk_en == 1'b0, "R1 en during arst", sys_clk_en, 0);
    arst_n = 1;
    wait_cyc(1);
    check(sys_rst == 1'b1, "R1 rst after 1 edge", sys_rst, 1);
    wait_cyc(1);
    check(sys_rst == 1'b0, "R1 rst after 2 edges", sys_rst, 0);
  endtask

  task automatic t_slow();
    clear_stats(1);
    wait_cyc(350);
    check(n_gaps >= 2, "R2 slow gaps seen", n_gaps, 2);
    check(min_gap == 100 && max_gap == 100, "R2 slow period", min_gap, 100);
    check(wide_cnt == 0, "R9 slow width", wide_cnt, 0);
  endtask

  task automatic t_fast();
    rate_fast = 1;
    wait_cyc(40);
    clear_stats(1);
    wait_cyc(200);
    check(n_gaps >= 8, "R3 fast gaps seen", n_gaps, 8);
    check(min_gap == 20 && max_gap == 20, "R3 fast period", max_gap, 20);
    check(wide_cnt == 0, "R9 fast width", wide_cnt, 0);
  endtask

  task automatic t_rate_change();
    do @(negedge clk); while (!sys_clk_en);
    #1;
    wait_cyc(10);
    clear_stats(0);
    rate_fast = 0;
    wait_cyc(320);
    check(first_gap >= 110 && first_gap <= 120, "R4 gap across change", first_gap, 113);
    check(n_gaps >= 2 && max_gap <= 120, "R4 later periods", max_gap, 100);
  endtask

  task automatic t_halt();
    rate_fast = 1;
    wait_cyc(60);
    halt_n = 0;
    wait_cyc(2);
    clear_stats(1);
    wait_cyc(100);
    check(pulse_cnt == 0, "R7 no pulse while halted", pulse_cnt, 0);
    halt_n = 1;
    clear_stats(1);
    wait_cyc(70);
    check(pulse_cnt >= 2 && min_gap == 20, "R7 resume after halt", pulse_cnt, 3);
  endtask

  task automatic t_step();
    auto_mode = 0;
    wait_cyc(10);
    clear_stats(1);
    for (int i = 0; i < 3; i++) press(20);
    check(pulse_cnt == 3, "R5 one pulse per press", pulse_cnt, 3);
    check(wide_cnt == 0, "R9 step width", wide_cnt, 0);
  endtask

  task automatic t_glitch();
    clear_stats(1);
    step_btn = 1; wait_cyc(2); step_btn = 0; wait_cyc(20);
    check(pulse_cnt == 0, "R6 step glitch ignored", pulse_cnt, 0);
    reset_btn = 1; wait_cyc(2); reset_btn = 0; wait_cyc(20);
    check(rst_seen == 1'b0, "R6 reset glitch ignored", rst_seen, 0);
  endtask

  task automatic t_step_halt();
    halt_n = 0;
    wait_cyc(2);
    clear_stats(1);
    press(20);
    check(pulse_cnt == 0, "R7 step while halted", pulse_cnt, 0);
    halt_n = 1;
    wait_cyc(5);
  endtask

  task automatic t_reset_btn();
    auto_mode = 1; rate_fast = 1;
    wait_cyc(50);
    reset_btn = 1;
    wait_cyc(12);
    clear_stats(1);
    wait_cyc(40);
    check(sys_rst == 1'b1, "R8 reset held", sys_rst, 1);
    check(pulse_cnt == 0, "R8 no pulse in reset", pulse_cnt, 0);
    reset_btn = 0;
    wait_cyc(15);
    check(sys_rst == 1'b0, "R8 reset released", sys_rst, 0);
    clear_stats(1);
    wait_cyc(70);
    check(pulse_cnt >= 2, "R8 clocking resumes", pulse_cnt, 3);
  endtask

  initial begin
    #(8 * 150_000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_slow();
    t_fast();
    t_rate_change();
    t_halt();
    t_step();
    t_glitch();
    t_step_halt();
    t_reset_btn();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule